// File: doc/BRIEF.md
# Outstanding Transaction Overlap Checker

This block sits on the requesting side of a memory-mapped bus. It decides whether a new read or write may be issued now, or whether it has to wait for earlier transactions of the opposite direction to finish. The bus keeps no ordering between reads and writes. The block therefore records the byte range of every outstanding read and every outstanding write, each direction in its own table.

A new memory request is held back only when its byte range overlaps an incomplete transaction of the other direction. A request into the peripheral region is held back while any transaction of the other direction is outstanding, whatever its address. A read leaves its table when its final data beat returns. A write leaves its table only when its write response arrives. The block sees neither the data channels nor their handshakes. It is told of issue events and completions, and it answers with a single permit signal.

Top module: `ovl_issue_gate`

## Requirements
- R1: After reset both tables are empty, and any valid request, memory or peripheral, of either direction is permitted.
- R2: `req_permit` is low whenever `req_valid` is low.
- R3: A memory request (`req_is_wr`=1 write, 0 read) is refused while its byte range overlaps the range of a valid entry of the other direction. Both range ends are inclusive, so sharing a single byte counts as an overlap.
- R4: A memory request whose range does not overlap any entry of the other direction is permitted. This holds even when it is directly adjacent to such an entry, and even while other entries of that direction are outstanding.
- R5: The byte range of a request is [addr, addr + (len+1) * 2^size - 1]. `len` is the beat count minus one and `size` is log2 of the bytes per beat.
- R6: A request whose address satisfies (addr & PERIPH_MASK) == PERIPH_BASE (default 0xF000_0000 for both) is refused while any entry of the other direction is outstanding. It is permitted once that table is empty.
- R7: Outstanding entries of the same direction never block a request.
- R8: A direction whose table holds DEPTH (default 8) entries refuses further requests of that direction. The other direction is unaffected apart from R3 and R6.
- R9: A read entry is released only by `rd_done_valid`, and a write entry only by `wr_done_valid`. A completion whose ID matches no entry of its table changes nothing.
- R10: When several entries of one table carry the completion's ID, the oldest is released first.
- R11: An entry is recorded only in a cycle with `req_issue` and `req_permit` both high. A release and an issue in the same cycle are both applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is presented for evaluation |
| req_is_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Beats minus one |
| req_size | input | SIZE_W | log2 of bytes per beat |
| req_id | input | ID_W | Transaction ID stored with the entry |
| req_issue | input | 1 | The request is issued this cycle if permitted |
| req_permit | output | 1 | The presented request may be issued now |
| rd_done_valid | input | 1 | Final read data beat returned |
| rd_done_id | input | ID_W | ID of the completed read |
| wr_done_valid | input | 1 | Write response received |
| wr_done_id | input | ID_W | ID of the completed write |

## Verification
The main function is tried with probes against a fixed pair of outstanding entries. The probes either share the first or the last byte of an entry, sit one byte beside it, or straddle it through a longer burst or a wider beat. This separates inclusive from exclusive range ends, and a correct length-times-size span from an off-by-one beat count. Probes of the same direction and probes into the peripheral window show that blocking depends on direction and region, not on address alone. Completion sequences then tell the response-based write release apart from any release on the wrong channel or an unmatched ID, and show oldest-first release among entries that share an ID.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  // Table index for each tracked direction
  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } ovl_dir_e;

  localparam int OVL_NDIR = 2;
endpackage

// File: rtl/ovl_rst_sync.sv
module ovl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ovl_range_cmp.sv
module ovl_range_cmp #(
  parameter int DEPTH = 8,
  parameter int EXT_W = 33
) (
  input  logic [EXT_W-1:0]            lo_i,
  input  logic [EXT_W-1:0]            hi_i,
  input  logic [DEPTH-1:0]            ent_vld_i,
  input  logic [DEPTH-1:0][EXT_W-1:0] ent_lo_i,
  input  logic [DEPTH-1:0][EXT_W-1:0] ent_hi_i,
  output logic [DEPTH-1:0]            hit_o
);
  // One inclusive interval test per stored entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign hit_o[g] = ent_vld_i[g] &&
                      (ent_lo_i[g] <= hi_i) &&
                      (lo_i <= ent_hi_i[g]);
  end
endmodule

// File: rtl/ovl_track_table.sv
module ovl_track_table #(
  parameter  int DEPTH = 8,
  parameter  int ID_W  = 4,
  parameter  int EXT_W = 33,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        alloc_i,
  input  logic [EXT_W-1:0]            alloc_lo_i,
  input  logic [EXT_W-1:0]            alloc_hi_i,
  input  logic [ID_W-1:0]             alloc_id_i,
  input  logic                        rel_i,
  input  logic [ID_W-1:0]             rel_id_i,
  output logic [DEPTH-1:0]            vld_o,
  output logic [DEPTH-1:0][EXT_W-1:0] lo_o,
  output logic [DEPTH-1:0][EXT_W-1:0] hi_o,
  output logic [CNT_W-1:0]            cnt_o,
  output logic                        full_o,
  output logic                        empty_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // Entries are kept compacted: slot 0 is the oldest, valid slots form a prefix.
  logic [DEPTH-1:0]            vld_q, vld_d;
  logic [DEPTH-1:0][EXT_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [DEPTH-1:0][ID_W-1:0]  id_q, id_d;
  logic [CNT_W-1:0]            cnt_q, cnt_d, cnt_left;

  // Arrays padded by one empty slot so a shift-down never indexes out of range
  logic [DEPTH:0]              vld_x;
  logic [DEPTH:0][EXT_W-1:0]   lo_x, hi_x;
  logic [DEPTH:0][ID_W-1:0]    id_x;

  logic             found;
  logic [IDX_W-1:0] hit_idx;
  logic             rel_hit;
  logic             alloc_ok;
  logic             upd;

  assign vld_x = {1'b0, vld_q};
  assign lo_x  = {{EXT_W{1'b0}}, lo_q};
  assign hi_x  = {{EXT_W{1'b0}}, hi_q};
  assign id_x  = {{ID_W{1'b0}}, id_q};

  always_comb begin : find_oldest
    found   = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && vld_q[i] && (id_q[i] == rel_id_i)) begin
        found   = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign rel_hit  = rel_i & found;
  assign cnt_left = cnt_q - CNT_W'(rel_hit);
  assign alloc_ok = alloc_i && (cnt_left < CNT_W'(DEPTH));
  assign cnt_d    = cnt_left + CNT_W'(alloc_ok);
  assign upd      = rel_hit | alloc_ok;

  always_comb begin : next_state
    vld_d = vld_q;
    lo_d  = lo_q;
    hi_d  = hi_q;
    id_d  = id_q;
    if (rel_hit) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (IDX_W'(i) >= hit_idx) begin
          vld_d[i] = vld_x[i+1];
          lo_d[i]  = lo_x[i+1];
          hi_d[i]  = hi_x[i+1];
          id_d[i]  = id_x[i+1];
        end
      end
    end
    if (alloc_ok) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == cnt_left) begin
          vld_d[i] = 1'b1;
          lo_d[i]  = alloc_lo_i;
          hi_d[i]  = alloc_hi_i;
          id_d[i]  = alloc_id_i;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin : ctl_regs
    if (!rst_n) begin
      vld_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      vld_q <= vld_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin : data_regs
    if (upd) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
      id_q <= id_d;
    end
  end

  assign vld_o   = vld_q;
  assign lo_o    = lo_q;
  assign hi_o    = hi_q;
  assign cnt_o   = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/ovl_issue_gate.sv
module ovl_issue_gate
  import ovl_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                LEN_W       = 8,
  parameter int                SIZE_W      = 3,
  parameter int                ID_W        = 4,
  parameter int                DEPTH       = 8,
  parameter logic [ADDR_W-1:0] PERIPH_BASE = 'hF000_0000,
  parameter logic [ADDR_W-1:0] PERIPH_MASK = 'hF000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_issue,
  output logic              req_permit,
  input  logic              rd_done_valid,
  input  logic [ID_W-1:0]   rd_done_id,
  input  logic              wr_done_valid,
  input  logic [ID_W-1:0]   wr_done_id
);
  // One extra bit keeps the end of a burst near the top of memory from wrapping
  localparam int EXT_W = ADDR_W + 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic rst_n_sync;

  ovl_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // Byte range of the presented request (R5)
  logic [EXT_W-1:0] beats, span, req_lo, req_hi;
  assign beats  = EXT_W'(req_len) + EXT_W'(1);
  assign span   = beats << req_size;
  assign req_lo = EXT_W'(req_addr);
  assign req_hi = req_lo + span - EXT_W'(1);

  logic [OVL_NDIR-1:0]                       alloc, rel, full, empty;
  logic [OVL_NDIR-1:0][ID_W-1:0]             rel_id;
  logic [OVL_NDIR-1:0][DEPTH-1:0]            vld, hit;
  logic [OVL_NDIR-1:0][DEPTH-1:0][EXT_W-1:0] ent_lo, ent_hi;
  logic [OVL_NDIR-1:0][CNT_W-1:0]            cnt;

  assign rel[DIR_RD]    = rd_done_valid;
  assign rel_id[DIR_RD] = rd_done_id;
  assign rel[DIR_WR]    = wr_done_valid;
  assign rel_id[DIR_WR] = wr_done_id;

  ovl_dir_e own_dir, opp_dir;
  assign own_dir = req_is_wr ? DIR_WR : DIR_RD;
  assign opp_dir = req_is_wr ? DIR_RD : DIR_WR;

  for (genvar d = 0; d < OVL_NDIR; d++) begin : g_dir
    assign alloc[d] = req_issue & req_permit & (own_dir == ovl_dir_e'(d));

    ovl_track_table #(
      .DEPTH (DEPTH),
      .ID_W  (ID_W),
      .EXT_W (EXT_W)
    ) u_tbl (
      .clk        (clk),
      .rst_n      (rst_n_sync),
      .alloc_i    (alloc[d]),
      .alloc_lo_i (req_lo),
      .alloc_hi_i (req_hi),
      .alloc_id_i (req_id),
      .rel_i      (rel[d]),
      .rel_id_i   (rel_id[d]),
      .vld_o      (vld[d]),
      .lo_o       (ent_lo[d]),
      .hi_o       (ent_hi[d]),
      .cnt_o      (cnt[d]),
      .full_o     (full[d]),
      .empty_o    (empty[d])
    );

    ovl_range_cmp #(
      .DEPTH (DEPTH),
      .EXT_W (EXT_W)
    ) u_cmp (
      .lo_i      (req_lo),
      .hi_i      (req_hi),
      .ent_vld_i (vld[d]),
      .ent_lo_i  (ent_lo[d]),
      .ent_hi_i  (ent_hi[d]),
      .hit_o     (hit[d])
    );
  end

  logic req_periph, own_full, opp_empty, opp_hit;
  assign req_periph = (req_addr & PERIPH_MASK) == PERIPH_BASE;
  assign own_full   = full[own_dir];
  assign opp_empty  = empty[opp_dir];
  assign opp_hit    = |hit[opp_dir];

  assign req_permit = req_valid & ~own_full &
                      (req_periph ? opp_empty : ~opp_hit);

  // Occupancy seen by the bound checker
  logic [CNT_W-1:0] cnt_rd, cnt_wr;
  assign cnt_rd = cnt[DIR_RD];
  assign cnt_wr = cnt[DIR_WR];
endmodule

// File: rtl/ovl_issue_gate_chk.sv
module ovl_issue_gate_chk #(
  parameter int                ADDR_W      = 32,
  parameter int                DEPTH       = 8,
  parameter int                CNT_W       = 4,
  parameter logic [ADDR_W-1:0] PERIPH_BASE = 'hF000_0000,
  parameter logic [ADDR_W-1:0] PERIPH_MASK = 'hF000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_is_wr,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_issue,
  input logic              req_permit,
  input logic              wr_done_valid,
  input logic [CNT_W-1:0]  cnt_rd,
  input logic [CNT_W-1:0]  cnt_wr
);
  logic in_periph;
  assign in_periph = (req_addr & PERIPH_MASK) == PERIPH_BASE;

  // R2
  permit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_permit |-> req_valid);

  // R8
  wr_full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_wr && cnt_wr == CNT_W'(DEPTH)) |-> !req_permit);

  // R8
  rd_full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_wr && cnt_rd == CNT_W'(DEPTH)) |-> !req_permit);

  // R8
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rd <= CNT_W'(DEPTH)) && (cnt_wr <= CNT_W'(DEPTH)));

  // R6
  periph_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_periph && (req_is_wr ? (cnt_rd != '0) : (cnt_wr != '0)))
      |-> !req_permit);

  // R9
  wr_release_on_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_done_valid |=> (cnt_wr >= $past(cnt_wr)));

  // R11
  no_record_without_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_issue && req_permit) |=> ((cnt_wr <= $past(cnt_wr)) && (cnt_rd <= $past(cnt_rd))));
endmodule

bind ovl_issue_gate ovl_issue_gate_chk #(
  .ADDR_W      (ADDR_W),
  .DEPTH       (DEPTH),
  .CNT_W       (CNT_W),
  .PERIPH_BASE (PERIPH_BASE),
  .PERIPH_MASK (PERIPH_MASK)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_is_wr     (req_is_wr),
  .req_addr      (req_addr),
  .req_issue     (req_issue),
  .req_permit    (req_permit),
  .wr_done_valid (wr_done_valid),
  .cnt_rd        (cnt_rd),
  .cnt_wr        (cnt_wr)
);

// File: tb/ovl_issue_gate_bench.sv
`timescale 1ns/1ps
module ovl_issue_gate_bench;
  logic        clk;
  logic        rst_n;
  logic        req_valid, req_is_wr, req_issue;
  logic [31:0] req_addr;
  logic [7:0]  req_len;
  logic [2:0]  req_size;
  logic [3:0]  req_id;
  logic        req_permit;
  logic        rd_done_valid, wr_done_valid;
  logic [3:0]  rd_done_id, wr_done_id;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ovl_issue_gate u_ovl_issue_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_is_wr     (req_is_wr),
    .req_addr      (req_addr),
    .req_len       (req_len),
    .req_size      (req_size),
    .req_id        (req_id),
    .req_issue     (req_issue),
    .req_permit    (req_permit),
    .rd_done_valid (rd_done_valid),
    .rd_done_id    (rd_done_id),
    .wr_done_valid (wr_done_valid),
    .wr_done_id    (wr_done_id)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Vector fields: {is_wr, addr[31:0], len[7:0], size[2:0], expected permit}
  // Outstanding at walk time: write [0x1000,0x100F] id1, read [0x2000,0x2007] id2
  localparam int NVEC = 13;
  localparam logic [44:0] VEC [NVEC] = '{
    {1'b0, 32'h0000_1000, 8'd0,  3'd0, 1'b0},  // R3 first byte shared
    {1'b0, 32'h0000_100F, 8'd0,  3'd0, 1'b0},  // R3 last byte shared
    {1'b0, 32'h0000_1010, 8'd0,  3'd0, 1'b1},  // R4 adjacent above
    {1'b0, 32'h0000_0FFF, 8'd0,  3'd0, 1'b1},  // R4 adjacent below
    {1'b0, 32'h0000_0FFF, 8'd0,  3'd1, 1'b0},  // R5 wider beat reaches 0x1000
    {1'b0, 32'h0000_0F00, 8'd15, 3'd4, 1'b1},  // R5 256 bytes end at 0xFFF
    {1'b0, 32'h0000_0F00, 8'd16, 3'd4, 1'b0},  // R5 272 bytes reach 0x100F
    {1'b1, 32'h0000_2007, 8'd0,  3'd0, 1'b0},  // R3 write on read end
    {1'b1, 32'h0000_2008, 8'd0,  3'd0, 1'b1},  // R4 write past read end
    {1'b1, 32'h0000_1000, 8'd0,  3'd0, 1'b1},  // R7 write over write
    {1'b0, 32'h0000_2000, 8'd0,  3'd0, 1'b1},  // R7 read over read
    {1'b0, 32'hF000_0000, 8'd0,  3'd0, 1'b0},  // R6 periph read, write pending
    {1'b1, 32'hF000_0040, 8'd0,  3'd0, 1'b0}   // R6 periph write, read pending
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: req_permit=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic put_req(input bit wr, input logic [31:0] a, input logic [7:0] l,
                         input logic [2:0] s, input logic [3:0] id, input bit iss);
    @(negedge clk);
    req_valid = 1'b1; req_is_wr = wr; req_addr = a;
    req_len = l; req_size = s; req_id = id; req_issue = iss;
  endtask

  task automatic probe(input string tag, input bit wr, input logic [31:0] a,
                       input logic [7:0] l, input logic [2:0] s, input logic exp);
    put_req(wr, a, l, s, 4'd0, 1'b0);
    #1;
    check(tag, req_permit, exp);
  endtask

  task automatic issue(input string tag, input bit wr, input logic [31:0] a,
                       input logic [7:0] l, input logic [2:0] s, input logic [3:0] id);
    put_req(wr, a, l, s, id, 1'b1);
    #1;
    check(tag, req_permit, 1'b1);
    @(posedge clk); #1;
    req_issue = 1'b0; req_valid = 1'b0;
  endtask

  task automatic rd_done(input logic [3:0] id);
    @(negedge clk);
    req_valid = 1'b0; req_issue = 1'b0;
    rd_done_valid = 1'b1; rd_done_id = id;
    @(posedge clk); #1;
    rd_done_valid = 1'b0;
  endtask

  task automatic wr_done(input logic [3:0] id);
    @(negedge clk);
    req_valid = 1'b0; req_issue = 1'b0;
    wr_done_valid = 1'b1; wr_done_id = id;
    @(posedge clk); #1;
    wr_done_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin : main
    rst_n = 1'b0;
    req_valid = 0; req_is_wr = 0; req_issue = 0;
    req_addr = '0; req_len = '0; req_size = '0; req_id = '0;
    rd_done_valid = 0; rd_done_id = '0; wr_done_valid = 0; wr_done_id = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: empty after reset, everything permitted
    probe("R1 mem read after reset",     1'b0, 32'h0000_1000, 8'd0, 3'd0, 1'b1);
    probe("R1 periph write after reset", 1'b1, 32'hF000_0000, 8'd0, 3'd0, 1'b1);
    // R2: no valid, no permit
    put_req(1'b0, 32'h0000_1000, 8'd0, 3'd0, 4'd0, 1'b0);
    req_valid = 1'b0; #1;
    check("R2 permit without valid", req_permit, 1'b0);

    // Set up the two outstanding entries for the table walk
    issue("R4 setup write",  1'b1, 32'h0000_1000, 8'd3, 3'd2, 4'd1);
    issue("R4 setup read",   1'b0, 32'h0000_2000, 8'd0, 3'd3, 4'd2);

    for (int v = 0; v < NVEC; v++) begin
      probe($sformatf("R3-R7 vector %0d", v), VEC[v][44], VEC[v][43:12],
            VEC[v][11:4], VEC[v][3:1], VEC[v][0]);
    end

    // R9: wrong channel and unmatched ID release nothing
    rd_done(4'd1);
    probe("R9 read done id1 leaves write",  1'b0, 32'h0000_1000, 8'd0, 3'd0, 1'b0);
    probe("R9 read done id1 keeps read id2", 1'b1, 32'h0000_2000, 8'd0, 3'd0, 1'b0);
    wr_done(4'd9);
    probe("R9 unmatched write id",          1'b0, 32'h0000_1000, 8'd0, 3'd0, 1'b0);
    wr_done(4'd1);
    probe("R9 write response releases",     1'b0, 32'h0000_1000, 8'd0, 3'd0, 1'b1);
    probe("R6 periph read after drain",     1'b0, 32'hF000_0000, 8'd0, 3'd0, 1'b1);
    probe("R6 periph write still blocked",  1'b1, 32'hF000_0000, 8'd0, 3'd0, 1'b0);
    rd_done(4'd2);
    probe("R6 periph write after drain",    1'b1, 32'hF000_0000, 8'd0, 3'd0, 1'b1);

    // R11: refused issue leaves no entry
    issue("R11 write 0x3000", 1'b1, 32'h0000_3000, 8'd0, 3'd0, 4'd3);
    put_req(1'b0, 32'h0000_3000, 8'd0, 3'd0, 4'd4, 1'b1);
    #1;
    check("R11 read over write refused", req_permit, 1'b0);
    @(posedge clk); #1;
    wr_done(4'd3);
    probe("R11 refused read not recorded", 1'b1, 32'hF000_0000, 8'd0, 3'd0, 1'b1);

    // R8: fill the read table
    for (int i = 0; i < 8; i++) begin
      issue($sformatf("R8 fill read %0d", i), 1'b0, 32'h0000_4000 + 32'(i * 16),
            8'd0, 3'd0, 4'(i));
    end
    probe("R8 full read table",             1'b0, 32'h0000_8000, 8'd0, 3'd0, 1'b0);
    probe("R8 write unaffected",            1'b1, 32'h0000_9000, 8'd0, 3'd0, 1'b1);
    probe("R3 write over newest read",      1'b1, 32'h0000_4070, 8'd0, 3'd0, 1'b0);
    rd_done(4'd0);
    probe("R8 slot freed",                  1'b0, 32'h0000_8000, 8'd0, 3'd0, 1'b1);
    probe("R9 released range open",         1'b1, 32'h0000_4000, 8'd0, 3'd0, 1'b1);
    for (int i = 1; i < 8; i++) rd_done(4'(i));
    probe("R8 read table drained",          1'b1, 32'hF000_0000, 8'd0, 3'd0, 1'b1);

    // R10: oldest of equal IDs goes first
    issue("R10 read A", 1'b0, 32'h0000_5000, 8'd0, 3'd0, 4'd5);
    issue("R10 read B", 1'b0, 32'h0000_6000, 8'd0, 3'd0, 4'd5);
    issue("R10 read C", 1'b0, 32'h0000_7000, 8'd0, 3'd0, 4'd5);
    rd_done(4'd5);
    probe("R10 oldest A released", 1'b1, 32'h0000_5000, 8'd0, 3'd0, 1'b1);
    probe("R10 B still held",      1'b1, 32'h0000_6000, 8'd0, 3'd0, 1'b0);
    rd_done(4'd5);
    probe("R10 B released",        1'b1, 32'h0000_6000, 8'd0, 3'd0, 1'b1);
    probe("R10 C still held",      1'b1, 32'h0000_7000, 8'd0, 3'd0, 1'b0);

    // R11: issue and release in the same cycle
    put_req(1'b0, 32'h0000_7100, 8'd0, 3'd0, 4'd6, 1'b1);
    rd_done_valid = 1'b1; rd_done_id = 4'd5;
    #1;
    check("R11 same-cycle issue permitted", req_permit, 1'b1);
    @(posedge clk); #1;
    req_issue = 1'b0; req_valid = 1'b0; rd_done_valid = 1'b0;
    probe("R11 same-cycle release applied", 1'b1, 32'h0000_7000, 8'd0, 3'd0, 1'b1);
    probe("R11 same-cycle issue recorded",  1'b1, 32'h0000_7100, 8'd0, 3'd0, 1'b0);

    finish_run();
  end
endmodule